// File: doc/BRIEF.md
# Half to Single Precision Widener

This block takes a 16-bit half-precision floating-point operand and turns it into the equivalent 32-bit single-precision value. Every half value can be represented exactly in single precision, so no rounding is done. The conversion covers signed zeros, subnormals (which are renormalized), normal values, infinities and NaNs. It also raises an invalid-operation flag when a signalling NaN is quieted.

A mode input chooses how the all-ones half exponent is read. With the mode clear, the operand is standard IEEE half precision: the top exponent code encodes infinity and NaN. With the mode set, the operand uses an extended-range half format that has no special values. The top exponent code is then an ordinary finite exponent. The unit has one register stage. An operand presented with its valid strobe at a rising clock edge has its result on the outputs after that edge, and the result stays there until the next strobed operand.

Top module: `half_widen_unit`

## Requirements
- R1: While reset is asserted, and after it until the first strobed operand, outValid, singleOut and invalidFlag are all zero.
- R2: outValid is high in the cycle after an edge at which inValid was high, and low in the cycle after an edge at which inValid was low.
- R3: When inValid is low at an edge, singleOut and invalidFlag keep their values, whatever halfIn and altMode carry.
- R4: An operand whose exponent field (bits 14:10) and fraction field (bits 9:0) are both zero gives a single zero that keeps the operand's sign.
- R5: An operand with a zero exponent and a nonzero fraction is a subnormal. The leading one of the fraction becomes the hidden bit. The single exponent is 112 minus the number of leading zeros in the 10-bit fraction. The remaining fraction bits are placed at the top of the 23-bit field.
- R6: An operand with an exponent from 1 to 30 (or 31 with altMode set) gives a single exponent equal to its own plus 112, and its fraction shifted left by 13.
- R7: With altMode low, exponent 31 with a zero fraction gives a single infinity of the same sign (exponent 255, fraction zero).
- R8: With altMode low, exponent 31 with a nonzero fraction gives a single NaN of the same sign. Its exponent is 255 and its fraction is the operand fraction with bit 9 forced to 1, shifted left by 13.
- R9: With altMode high, exponent 31 is finite. It gives single exponent 143, never an infinity or NaN, and never raises invalidFlag.
- R10: invalidFlag is 1 only for a signalling NaN: altMode low, exponent 31, fraction nonzero, fraction bit 9 clear. It is 0 for every other operand.
- R11: Bit 31 of every result equals bit 15 of the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand strobe; halfIn and altMode are taken at an edge where it is high |
| altMode | input | 1 | 0: IEEE half format; 1: extended-range half format with no special values |
| halfIn | input | 16 | Half-precision operand (sign 15, exponent 14:10, fraction 9:0) |
| outValid | output | 1 | High for one cycle per strobed operand, one edge after it |
| singleOut | output | 32 | Single-precision result |
| invalidFlag | output | 1 | Signalling NaN quieted |

## Verification
Every result is due exactly one rising edge after its operand is strobed. The bench drives on falling edges and reads outputs on the next falling edge, half a period after the edge that loads them. In the exhaustive sweep, a new operand goes in every cycle. At each falling edge the bench first compares the output against the operand that was driven one cycle earlier, and only then drives the next operand. The hold scenario samples several cycles with no strobe, to show that the registered result does not move.

// File: rtl/hw_widen_pkg.sv
package hw_widen_pkg;
  localparam int unsigned HALF_EXP_W  = 5;
  localparam int unsigned HALF_FRAC_W = 10;
  localparam int unsigned SGL_EXP_W   = 8;
  localparam int unsigned SGL_FRAC_W  = 23;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUBNORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_NAN
  } halfClass_t;

  typedef struct packed {
    logic capture;
    logic altSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/hw_lead_zero.sv
module hw_lead_zero #(
  parameter int unsigned W    = 10,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] zeroCount
);
  always_comb begin
    logic seenOne;
    seenOne   = 1'b0;
    zeroCount = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!seenOne) begin
        if (vec[i]) seenOne = 1'b1;
        else        zeroCount = zeroCount + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hw_widen_control.sv
module hw_widen_control
  import hw_widen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         altMode,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  always_comb begin
    strobes.capture = inValid;
    strobes.altSel  = altMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/hw_widen_datapath.sv
module hw_widen_datapath
  import hw_widen_pkg::*;
#(
  parameter int unsigned H_EXP_W  = HALF_EXP_W,
  parameter int unsigned H_FRAC_W = HALF_FRAC_W,
  parameter int unsigned S_EXP_W  = SGL_EXP_W,
  parameter int unsigned S_FRAC_W = SGL_FRAC_W,
  localparam int unsigned H_W     = 1 + H_EXP_W + H_FRAC_W,
  localparam int unsigned S_W     = 1 + S_EXP_W + S_FRAC_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobes_t   strobes,
  input  logic [H_W-1:0] halfIn,
  output logic [S_W-1:0] singleOut,
  output logic           invalidFlag
);
  localparam int unsigned LZ_W       = $clog2(H_FRAC_W + 1);
  localparam int unsigned FRAC_SHIFT = S_FRAC_W - H_FRAC_W;
  localparam int unsigned QUIET_BIT  = H_FRAC_W - 1;
  localparam int unsigned EXP_OFFSET = (1 << (S_EXP_W - 1)) - (1 << (H_EXP_W - 1));

  logic                halfSign;
  logic [H_EXP_W-1:0]  halfExp;
  logic [H_FRAC_W-1:0] halfFrac;
  logic                expTop, expZero, fracZero;
  halfClass_t          opClass;
  logic [LZ_W-1:0]     lzCount;
  logic [LZ_W-1:0]     shiftAmt;
  logic [H_FRAC_W-1:0] subFrac;
  logic [H_FRAC_W-1:0] quietFrac;
  logic [S_EXP_W-1:0]  resExp;
  logic [H_FRAC_W-1:0] resFrac;
  logic                resInvalid;

  assign halfSign = halfIn[H_W-1];
  assign halfExp  = halfIn[H_FRAC_W +: H_EXP_W];
  assign halfFrac = halfIn[H_FRAC_W-1:0];
  assign expTop   = &halfExp;
  assign expZero  = ~|halfExp;
  assign fracZero = ~|halfFrac;

  always_comb begin
    if (expTop && !strobes.altSel) opClass = fracZero ? CLS_INF : CLS_NAN;
    else if (expZero)              opClass = fracZero ? CLS_ZERO : CLS_SUBNORM;
    else                           opClass = CLS_NORMAL;
  end

  hw_lead_zero #(.W(H_FRAC_W), .CNT_W(LZ_W)) lzcInst (
    .vec      (halfFrac),
    .zeroCount(lzCount)
  );

  assign shiftAmt = lzCount + LZ_W'(1);
  assign subFrac  = halfFrac << shiftAmt;

  always_comb begin
    quietFrac            = halfFrac;
    quietFrac[QUIET_BIT] = 1'b1;
  end

  always_comb begin
    resExp     = '0;
    resFrac    = '0;
    resInvalid = 1'b0;
    unique case (opClass)
      CLS_ZERO: begin
        resExp  = '0;
        resFrac = '0;
      end
      CLS_SUBNORM: begin
        resExp  = S_EXP_W'(EXP_OFFSET) - S_EXP_W'(lzCount);
        resFrac = subFrac;
      end
      CLS_NORMAL: begin
        resExp  = S_EXP_W'(halfExp) + S_EXP_W'(EXP_OFFSET);
        resFrac = halfFrac;
      end
      CLS_INF: begin
        resExp  = '1;
        resFrac = '0;
      end
      CLS_NAN: begin
        resExp     = '1;
        resFrac    = quietFrac;
        resInvalid = ~halfFrac[QUIET_BIT];
      end
      default: begin
        resExp  = '0;
        resFrac = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleOut   <= '0;
      invalidFlag <= 1'b0;
    end else if (strobes.capture) begin
      singleOut   <= {halfSign, resExp, resFrac, {FRAC_SHIFT{1'b0}}};
      invalidFlag <= resInvalid;
    end
  end
endmodule

// File: rtl/half_widen_unit.sv
module half_widen_unit
  import hw_widen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        altMode,
  input  logic [15:0] halfIn,
  output logic        outValid,
  output logic [31:0] singleOut,
  output logic        invalidFlag
);
  ctrlStrobes_t strobes;

  hw_widen_control ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .altMode (altMode),
    .strobes (strobes),
    .outValid(outValid)
  );

  hw_widen_datapath dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .halfIn     (halfIn),
    .singleOut  (singleOut),
    .invalidFlag(invalidFlag)
  );
endmodule

// File: rtl/hw_widen_checker.sv
module hw_widen_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        altMode,
  input logic [15:0] halfIn,
  input logic        outValid,
  input logic [31:0] singleOut,
  input logic        invalidFlag
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid) |=> outValid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !inValid) |=> !outValid);

  assert_hold_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !inValid) |=> ($stable(singleOut) && $stable(invalidFlag)));

  assert_infinity_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && !altMode && halfIn[14:10] == 5'h1F && halfIn[9:0] == 10'h0)
      |=> singleOut[30:0] == 31'h7F80_0000);

  assert_alt_finite_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && altMode) |=> (singleOut[30:23] != 8'hFF && !invalidFlag));

  assert_flag_only_on_nan_R10: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> (singleOut[30:23] == 8'hFF && singleOut[22] && singleOut[21:0] != 22'h0));

  assert_sign_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid) |=> singleOut[31] == $past(halfIn[15]));
endmodule

bind half_widen_unit hw_widen_checker chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .altMode    (altMode),
  .halfIn     (halfIn),
  .outValid   (outValid),
  .singleOut  (singleOut),
  .invalidFlag(invalidFlag)
);

// File: tb/half_widen_unit_test.sv
module half_widen_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        altMode = 1'b0;
  logic [15:0] halfIn = 16'h0;
  logic        outValid;
  logic [31:0] singleOut;
  logic        invalidFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  half_widen_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .altMode(altMode),
    .halfIn(halfIn), .outValid(outValid), .singleOut(singleOut),
    .invalidFlag(invalidFlag)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refWiden(input logic [15:0] h, input logic alt,
                                          output logic inv, output string tag);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  f;
    logic [10:0] m;
    int          ue;
    s = h[15]; e = h[14:10]; f = h[9:0]; inv = 1'b0;
    if (e == 5'd31 && !alt) begin
      if (f == 10'd0) begin
        tag = "R7";
        return {s, 8'hFF, 23'd0};
      end
      tag = "R8";
      inv = !f[9];
      return {s, 8'hFF, f | 10'h200, 13'd0};
    end
    if (e == 5'd0 && f == 10'd0) begin
      tag = "R4";
      return {s, 31'd0};
    end
    if (e == 5'd0) begin
      m = {1'b0, f};
      ue = -14;
      while (!m[10]) begin
        m = m << 1;
        ue--;
      end
      tag = "R5";
    end else begin
      m = {1'b1, f};
      ue = int'(e) - 15;
      tag = (alt && e == 5'd31) ? "R9" : "R6";
    end
    return {s, 8'(ue + 127), m[9:0], 13'd0};
  endfunction

  task automatic applyOne(logic [15:0] h, logic alt, logic [31:0] expVal,
                          logic expInv, string tag);
    @(negedge clk);
    halfIn = h; altMode = alt; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check32("R2 outValid", {31'd0, outValid}, 32'd1);
    check32(tag, singleOut, expVal);
    check32("R10 invalidFlag", {31'd0, invalidFlag}, {31'd0, expInv});
  endtask

  task automatic testReset();
    check32("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    check32("R1 result in reset", singleOut, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check32("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    check32("R1 result after reset", singleOut, 32'd0);
    check32("R1 flag after reset", {31'd0, invalidFlag}, 32'd0);
  endtask

  task automatic testZeros();
    applyOne(16'h0000, 1'b0, 32'h0000_0000, 1'b0, "R4 +0");
    applyOne(16'h8000, 1'b0, 32'h8000_0000, 1'b0, "R4 -0 R11");
    applyOne(16'h8000, 1'b1, 32'h8000_0000, 1'b0, "R4 -0 alt");
  endtask

  task automatic testSubnormals();
    applyOne(16'h0001, 1'b0, 32'h3380_0000, 1'b0, "R5 smallest");
    applyOne(16'h03FF, 1'b0, 32'h387F_C000, 1'b0, "R5 largest");
    applyOne(16'h8200, 1'b1, 32'hB800_0000, 1'b0, "R5 negative alt");
  endtask

  task automatic testNormals();
    applyOne(16'h3C00, 1'b0, 32'h3F80_0000, 1'b0, "R6 one");
    applyOne(16'hC000, 1'b0, 32'hC000_0000, 1'b0, "R6 minus two R11");
    applyOne(16'h7BFF, 1'b0, 32'h477F_E000, 1'b0, "R6 max finite");
    applyOne(16'h0400, 1'b0, 32'h3880_0000, 1'b0, "R6 min normal");
  endtask

  task automatic testSpecials();
    applyOne(16'h7C00, 1'b0, 32'h7F80_0000, 1'b0, "R7 +inf");
    applyOne(16'hFC00, 1'b0, 32'hFF80_0000, 1'b0, "R7 -inf");
    applyOne(16'h7E00, 1'b0, 32'h7FC0_0000, 1'b0, "R8 quiet nan");
    applyOne(16'h7C01, 1'b0, 32'h7FC0_2000, 1'b1, "R8 signalling nan");
    applyOne(16'hFD55, 1'b0, 32'hFFEA_A000, 1'b1, "R8 negative signalling");
  endtask

  task automatic testAltMode();
    applyOne(16'h7C00, 1'b1, 32'h4780_0000, 1'b0, "R9 top exponent");
    applyOne(16'hFFFF, 1'b1, 32'hC7FF_E000, 1'b0, "R9 largest magnitude");
    applyOne(16'h7C01, 1'b1, 32'h4780_2000, 1'b0, "R9 no signalling R10");
  endtask

  task automatic testHold();
    applyOne(16'h7C01, 1'b0, 32'h7FC0_2000, 1'b1, "R8 before hold");
    halfIn = 16'h3C00; altMode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check32("R2 no strobe", {31'd0, outValid}, 32'd0);
      check32("R3 result held", singleOut, 32'h7FC0_2000);
      check32("R3 flag held", {31'd0, invalidFlag}, 32'd1);
    end
  endtask

  task automatic testSweep(logic alt);
    logic [31:0] expVal;
    logic        expInv;
    string       tag;
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check32(tag, singleOut, expVal);
        check32("R10 sweep", {31'd0, invalidFlag}, {31'd0, expInv});
      end
      if (i < 65536) begin
        halfIn = 16'(i); altMode = alt; inValid = 1'b1;
        expVal = refWiden(16'(i), alt, expInv, tag);
      end else begin
        inValid = 1'b0;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 195000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testZeros();
    testSubnormals();
    testNormals();
    testSpecials();
    testAltMode();
    testHold();
    testSweep(1'b0);
    testSweep(1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule